// File: doc/BRIEF.md
# Frame-synchronized serial configuration registers

This block receives configuration over a three-wire serial port (active-low chip select, serial clock, serial data) and holds the readout settings of an image-sensor controller. Every setting lives in two copies. The serial port writes the shadow copy. The readout logic sees only the active copy. The active copy is loaded from the shadow copy in any cycle where the frame-gap strobe is high. Gain, detector bias, integration time, window and output settings can therefore be rewritten while video streams. A frame already under way keeps one consistent set of values, so no frame is lost and no frame is glitched.

The serial lines are brought into the system clock domain through two-stage synchronizers and oversampled there. A transaction carries 8 address bits followed by 16 data bits, most significant bit first. The frame-gap strobe is synchronous to the system clock and is raised by the readout timing logic between frames.

Top module: `frame_cfg_regs`

## Requirements
- R1: After reset the active outputs read: gain code 1 (high), bias code 0x0800, integration time 1000, window origin column 0 and row 0, window size 1280 columns by 1024 rows, both flips off, output mode 2, sync enables 4'b1111.
- R2: While cs_ni is low, each rising sck_i samples sdi_i. A transaction of exactly 24 bits, 8 address bits then 16 data bits with the most significant bit first, writes that data into the shadow register at that address when cs_ni rises.
- R3: The active outputs change only after a clock edge at which frame_gap_i was high. A write that has been accepted does not appear on the outputs until the next such edge.
- R4: Gain code 0 selects very high gain, 1 selects high gain and 2 selects low gain. A write of code 3 to the gain register is rejected and the previous value is kept.
- R5: A transaction that has any bit count other than 24 when cs_ni rises is discarded.
- R6: If a write reaches the shadow copy at the same clock edge as a commit, that commit still carries the old value. The new value appears at the following commit.
- R7: The register addresses are:
  - 0: gain, in data[1:0].
  - 1: bias code, in data[15:0].
  - 2: integration time bits 15:0.
  - 3: integration time bits 23:16, taken from data[7:0].
  - 4: window column origin, 5: window row origin, 6: window column count, 7: window row count. Each of these four takes data[10:0].
  - Writes to any other address have no effect.
- R8: Address 8 is the control register:
  - data[0] is the horizontal flip.
  - data[1] is the vertical flip.
  - data[3:2] is the output mode.
  - data[7:4] are the sync enables for frame valid, line valid, data valid and pixel clock, in that order from bit 4 upward.
  - data[15:8] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Serial chip select, active low |
| sdi_i | input | 1 | Serial data in |
| frame_gap_i | input | 1 | Inter-frame strobe; when high, active is loaded from shadow |
| gain_o | output | 2 | Active gain code |
| bias_o | output | 16 | Active detector bias code, 0.7 mV per step |
| integ_o | output | 24 | Active integration time in clock steps |
| win_col_o | output | 11 | Active window column origin |
| win_row_o | output | 11 | Active window row origin |
| win_cols_o | output | 11 | Active window column count |
| win_rows_o | output | 11 | Active window row count |
| hflip_o | output | 1 | Active horizontal scan reversal |
| vflip_o | output | 1 | Active vertical scan reversal |
| out_mode_o | output | 2 | Active output mode |
| sync_en_o | output | 4 | Active enables for frame valid, line valid, data valid, pixel clock |

## Verification
A serial write and a frame-boundary commit can occur in the same clock cycle. The bench causes this by raising frame_gap_i exactly three clock edges after it raises chip select. Counting the two synchronizer stages and the write register, that is the edge at which the shadow copy is loaded. The outputs must show the old value after that commit, and must show the new value only after one further strobe. Separately, the bench reads the outputs after writes that were accepted but not yet committed, and confirms they have not moved.

// File: rtl/frame_cfg_pkg.sv
`timescale 1ns/1ps
package frame_cfg_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1) + 1;
  localparam int INT_W      = 24;
  localparam int COORD_W    = 11;
  localparam int SYNC_N     = 4;
  localparam int FULL_COLS  = 1280;
  localparam int FULL_ROWS  = 1024;

  typedef enum logic [1:0] {
    GAIN_VHIGH = 2'd0,
    GAIN_HIGH  = 2'd1,
    GAIN_LOW   = 2'd2,
    GAIN_BAD   = 2'd3
  } gain_e;

  localparam logic [ADDR_W-1:0] A_GAIN  = 8'd0;
  localparam logic [ADDR_W-1:0] A_BIAS  = 8'd1;
  localparam logic [ADDR_W-1:0] A_INTL  = 8'd2;
  localparam logic [ADDR_W-1:0] A_INTH  = 8'd3;
  localparam logic [ADDR_W-1:0] A_COL0  = 8'd4;
  localparam logic [ADDR_W-1:0] A_ROW0  = 8'd5;
  localparam logic [ADDR_W-1:0] A_NCOLS = 8'd6;
  localparam logic [ADDR_W-1:0] A_NROWS = 8'd7;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'd8;

  typedef struct packed {
    logic [1:0]         gain;
    logic [DATA_W-1:0]  bias;
    logic [INT_W-1:0]   integ;
    logic [COORD_W-1:0] col0;
    logic [COORD_W-1:0] row0;
    logic [COORD_W-1:0] ncols;
    logic [COORD_W-1:0] nrows;
    logic               hflip;
    logic               vflip;
    logic [1:0]         out_mode;
    logic [SYNC_N-1:0]  sync_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    gain:     GAIN_HIGH,
    bias:     16'h0800,
    integ:    INT_W'(1000),
    col0:     '0,
    row0:     '0,
    ncols:    COORD_W'(FULL_COLS),
    nrows:    COORD_W'(FULL_ROWS),
    hflip:    1'b0,
    vflip:    1'b0,
    out_mode: 2'd2,
    sync_en:  '1
  };
endpackage

// File: rtl/frame_cfg_sync.sv
`timescale 1ns/1ps
module frame_cfg_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[b]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/frame_cfg_serial_rx.sv
`timescale 1ns/1ps
module frame_cfg_serial_rx
  import frame_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic                  sck_q, cs_q;
  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  sck_rise, cs_rise, cs_fall;

  assign sck_rise = sck_i & ~sck_q;
  assign cs_rise  = cs_ni & ~cs_q;
  assign cs_fall  = ~cs_ni & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      wr_o  <= 1'b0;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (!cs_ni && sck_rise) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], sdi_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;  // saturate so long frames never alias to 24
      end
      if (cs_rise && cnt_q == CNT_W'(FRAME_BITS)) begin
        wr_o   <= 1'b1;
        addr_o <= shift_q[FRAME_BITS-1:DATA_W];
        data_o <= shift_q[DATA_W-1:0];
      end
    end
  end

  // R2: one transaction yields exactly one write strobe
  a_r2_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/frame_cfg_bank.sv
`timescale 1ns/1ps
module frame_cfg_bank
  import frame_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  output cfg_t              active_o
);
  cfg_t shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CFG_RST;
    end else if (wr_i) begin
      unique case (addr_i)
        A_GAIN:  if (data_i[1:0] != GAIN_BAD) shadow_q.gain <= data_i[1:0];
        A_BIAS:  shadow_q.bias  <= data_i;
        A_INTL:  shadow_q.integ[DATA_W-1:0] <= data_i;
        A_INTH:  shadow_q.integ[INT_W-1:DATA_W] <= data_i[INT_W-DATA_W-1:0];
        A_COL0:  shadow_q.col0  <= data_i[COORD_W-1:0];
        A_ROW0:  shadow_q.row0  <= data_i[COORD_W-1:0];
        A_NCOLS: shadow_q.ncols <= data_i[COORD_W-1:0];
        A_NROWS: shadow_q.nrows <= data_i[COORD_W-1:0];
        A_CTRL: begin
          shadow_q.hflip    <= data_i[0];
          shadow_q.vflip    <= data_i[1];
          shadow_q.out_mode <= data_i[3:2];
          shadow_q.sync_en  <= data_i[4+:SYNC_N];
        end
        default: ;
      endcase
    end
  end

  // a write in the commit cycle lands in shadow only after the copy is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= CFG_RST;
    else if (commit_i) active_q <= shadow_q;
  end

  assign active_o = active_q;

  a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(active_q));

  a_r4_no_illegal_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_q.gain != GAIN_BAD);

  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(shadow_q));
endmodule

// File: rtl/frame_cfg_regs.sv
`timescale 1ns/1ps
module frame_cfg_regs
  import frame_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               sdi_i,
  input  logic               frame_gap_i,
  output logic [1:0]         gain_o,
  output logic [DATA_W-1:0]  bias_o,
  output logic [INT_W-1:0]   integ_o,
  output logic [COORD_W-1:0] win_col_o,
  output logic [COORD_W-1:0] win_row_o,
  output logic [COORD_W-1:0] win_cols_o,
  output logic [COORD_W-1:0] win_rows_o,
  output logic               hflip_o,
  output logic               vflip_o,
  output logic [1:0]         out_mode_o,
  output logic [SYNC_N-1:0]  sync_en_o
);
  logic [2:0]        pins_s;
  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  cfg_t              active;

  frame_cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni, sdi_i}),
    .q_o    (pins_s)
  );

  frame_cfg_serial_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (pins_s[2]),
    .cs_ni  (pins_s[1]),
    .sdi_i  (pins_s[0]),
    .wr_o   (wr),
    .addr_o (wr_addr),
    .data_o (wr_data)
  );

  frame_cfg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .addr_i   (wr_addr),
    .data_i   (wr_data),
    .commit_i (frame_gap_i),
    .active_o (active)
  );

  assign gain_o     = active.gain;
  assign bias_o     = active.bias;
  assign integ_o    = active.integ;
  assign win_col_o  = active.col0;
  assign win_row_o  = active.row0;
  assign win_cols_o = active.ncols;
  assign win_rows_o = active.nrows;
  assign hflip_o    = active.hflip;
  assign vflip_o    = active.vflip;
  assign out_mode_o = active.out_mode;
  assign sync_en_o  = active.sync_en;
endmodule

// File: tb/frame_cfg_regs_tb.sv
`timescale 1ns/1ps
module frame_cfg_regs_tb;
  typedef logic [93:0] snap_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, gap = 1'b0;
  logic [1:0]  gain_o;
  logic [15:0] bias_o;
  logic [23:0] integ_o;
  logic [10:0] col_o, row_o, cols_o, rows_o;
  logic        hf_o, vf_o;
  logic [1:0]  mode_o;
  logic [3:0]  sync_o;

  always #5 clk = ~clk;

  frame_cfg_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .frame_gap_i(gap), .gain_o(gain_o), .bias_o(bias_o), .integ_o(integ_o),
    .win_col_o(col_o), .win_row_o(row_o), .win_cols_o(cols_o), .win_rows_o(rows_o),
    .hflip_o(hf_o), .vflip_o(vf_o), .out_mode_o(mode_o), .sync_en_o(sync_o)
  );

  int errors = 0;
  int checks = 0;

  // model of the shadow copy and of what must be on the outputs
  logic [1:0]  m_gain = 2'd1;
  logic [15:0] m_bias = 16'h0800;
  logic [23:0] m_integ = 24'd1000;
  logic [10:0] m_col = 0, m_row = 0, m_cols = 11'd1280, m_rows = 11'd1024;
  logic        m_hf = 0, m_vf = 0;
  logic [1:0]  m_mode = 2'd2;
  logic [3:0]  m_sync = 4'hF;
  snap_t       exp_active;

  snap_t exp_q[$];
  string tag_q[$];
  event  cmp_ev;

  function automatic snap_t model_snap();
    return {m_gain, m_bias, m_integ, m_col, m_row, m_cols, m_rows, m_hf, m_vf, m_mode, m_sync};
  endfunction

  function automatic bit accepts(input logic [7:0] a, input logic [15:0] d, input int nbits);
    if (nbits != 24) return 1'b0;
    if (a > 8'd8) return 1'b0;
    if (a == 8'd0 && d[1:0] == 2'd3) return 1'b0;
    return 1'b1;
  endfunction

  function automatic void model_apply(input logic [7:0] a, input logic [15:0] d);
    case (a)
      8'd0: m_gain = d[1:0];
      8'd1: m_bias = d;
      8'd2: m_integ[15:0] = d;
      8'd3: m_integ[23:16] = d[7:0];
      8'd4: m_col = d[10:0];
      8'd5: m_row = d[10:0];
      8'd6: m_cols = d[10:0];
      8'd7: m_rows = d[10:0];
      8'd8: begin m_hf = d[0]; m_vf = d[1]; m_mode = d[3:2]; m_sync = d[7:4]; end
      default: ;
    endcase
  endfunction

  function automatic void chk(input string tag, input string fld, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, fld, got, exp);
    end
  endfunction

  // monitor: pops expected snapshots and compares against the ports
  initial begin
    forever begin
      @(cmp_ev);
      while (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "gain",   64'(gain_o), 64'(e[93:92]));
        chk(t, "bias",   64'(bias_o), 64'(e[91:76]));
        chk(t, "integ",  64'(integ_o), 64'(e[75:52]));
        chk(t, "window", 64'({col_o, row_o, cols_o, rows_o}), 64'(e[51:8]));
        chk(t, "ctrl",   64'({hf_o, vf_o, mode_o, sync_o}), 64'(e[7:0]));
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_q.push_back(exp_active);
    tag_q.push_back(tag);
    ->cmp_ev;
    @(negedge clk);
  endtask

  task automatic commit(input string tag);
    @(negedge clk);
    gap = 1'b1;
    @(negedge clk);
    gap = 1'b0;
    exp_active = model_snap();
    expect_now(tag);
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d, input int nbits, input bit collide);
    logic [23:0] frm;
    frm = {a, d};
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? frm[23 - i] : 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (collide) begin
      // write reaches shadow on the 4th edge after cs_n rises; commit on that same edge
      repeat (3) @(posedge clk);
      @(negedge clk);
      gap = 1'b1;
      @(negedge clk);
      gap = 1'b0;
      exp_active = model_snap();
      expect_now("R6");
    end else begin
      repeat (6) @(negedge clk);
    end
    if (accepts(a, d, nbits)) model_apply(a, d);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_active = model_snap();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R1");

    // R3: accepted write invisible until frame gap
    send(8'd0, 16'h0000, 24, 1'b0);
    expect_now("R3");
    commit("R2");

    // R7: full map
    send(8'd1, 16'h1234, 24, 1'b0);
    send(8'd2, 16'h5678, 24, 1'b0);
    send(8'd3, 16'h12AB, 24, 1'b0);
    send(8'd4, 16'h0064, 24, 1'b0);
    send(8'd5, 16'h0032, 24, 1'b0);
    send(8'd6, 16'hFA80, 24, 1'b0);
    send(8'd7, 16'h01E0, 24, 1'b0);
    expect_now("R3");
    commit("R7");

    // R8: control fields, upper byte ignored
    send(8'd8, 16'hFF36, 24, 1'b0);
    commit("R8");
    send(8'd8, 16'h00C9, 24, 1'b0);
    commit("R8");

    // R4: illegal gain rejected, legal codes accepted
    send(8'd0, 16'h0003, 24, 1'b0);
    commit("R4");
    send(8'd0, 16'h0002, 24, 1'b0);
    commit("R4");
    send(8'd0, 16'hFFF3, 24, 1'b0);
    commit("R4");

    // R5: short and long frames discarded
    send(8'd1, 16'hDEAD, 23, 1'b0);
    send(8'd1, 16'hBEEF, 25, 1'b0);
    commit("R5");

    // R7: unknown addresses ignored
    send(8'd9, 16'hAAAA, 24, 1'b0);
    send(8'hFF, 16'h5555, 24, 1'b0);
    commit("R7");

    // R6: write coincides with commit
    send(8'd1, 16'h0BEE, 24, 1'b1);
    commit("R6");

    // R3: boundary without writes leaves outputs unchanged
    commit("R3");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule